// File: doc/BRIEF.md
# Adaptive Vertical Blanking Line Generator

This block closes a frame on a line-based pixel stream. After the last active line, it sends dummy blanking lines, each as long as the programmed frame width. It keeps sending them until every enabled downstream channel has reported that it has finished the frame. When the optional global-processing stage is switched on, the block also waits for that stage to report done. The blanking period therefore has no fixed length: it lasts exactly as long as the downstream consumers need. When completion arrives, the dummy line in progress stops at once and gets no end-of-line marker.

The controller has three states. `ST_IDLE` waits for `frame_start`. `ST_ACTIVE` covers the active frame. `ST_BLANK` emits the dummy lines. The transitions are:

- `ST_IDLE` to `ST_ACTIVE` on `frame_start`. This also clears the latched completion flags.
- `ST_ACTIVE` to `ST_IDLE` on `last_line_done` when `line_mode` is set, or when completion is already met.
- `ST_ACTIVE` to `ST_BLANK` on `last_line_done` otherwise.
- `ST_BLANK` to `ST_IDLE` in the cycle in which completion is met.

Line mode is a debug setting that skips blanking. Frame mode (`line_mode` = 0) is the normal setting.

Top module: `vblank_line_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `pix_valid`, `pix_sol`, `pix_eol` and `blank_active` are all 0, and the block waits in `ST_IDLE`.
- R2: In frame mode, a `last_line_done` pulse in `ST_ACTIVE` with completion not yet met puts the block into `ST_BLANK` from the next cycle. `blank_active` is 1 for every cycle spent in `ST_BLANK`.
- R3: In `ST_BLANK`, while completion is not met, `pix_valid` is 1 in every cycle and `pix_data` is all zeros.
- R4: Each dummy line is `frame_width` valid cycles long. `pix_sol` is 1 on its first pixel and `pix_eol` is 1 on its last pixel. A new line follows with no gap.
- R5: A `frame_width` of 0 gives dummy lines of one pixel, with `pix_sol` and `pix_eol` both 1 on that pixel.
- R6: Completion needs an end-of-processing pulse on `ch_eop[i]` for every channel i whose `ch_en[i]` is 1. A pulse counts from its own cycle onward and is held until the next `frame_start`, so pulses at different times all count. Channels with `ch_en[i]` = 0 are ignored.
- R7: With `glb_en` = 1, completion also needs a `glb_done` pulse, which is held in the same way as the channel pulses. With `glb_en` = 0, `glb_done` has no effect.
- R8: In the cycle where completion is met during `ST_BLANK`, `pix_valid`, `pix_sol` and `pix_eol` are 0, even on what would have been the last pixel of a line, while `blank_active` is still 1. The block is in `ST_IDLE` on the next cycle.
- R9: If completion is already met when `last_line_done` arrives, no dummy line is started and `blank_active` stays 0.
- R10: With `line_mode` = 1, `last_line_done` returns the block to `ST_IDLE` with no blanking at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| frame_start | input | 1 | Pulse that starts a frame; accepted in `ST_IDLE` |
| last_line_done | input | 1 | Pulse marking the end of the last active line |
| frame_width | input | WIDTH_W | Pixels per line; 0 is treated as 1 |
| ch_eop | input | NUM_CH | Per-channel end-of-processing pulses |
| ch_en | input | NUM_CH | Channel enable mask |
| glb_en | input | 1 | Enables waiting for the global-processing stage |
| glb_done | input | 1 | Completion pulse from the global-processing stage |
| line_mode | input | 1 | 1 selects debug line mode; 0 selects frame mode |
| pix_data | output | DATA_W | Dummy pixel data, always zero |
| pix_valid | output | 1 | Dummy pixel valid |
| pix_sol | output | 1 | Start-of-line marker |
| pix_eol | output | 1 | End-of-line marker |
| blank_active | output | 1 | High while in `ST_BLANK` |

## Verification
Two functions can fall in the same cycle: the end-of-line marker on the last pixel of a dummy line, and the arrival of the final completion pulse. The bench places a `glb_done` pulse exactly on the last pixel of a three-pixel line. It expects that cycle to show `blank_active` high with `pix_valid` and `pix_eol` low, and expects `ST_IDLE` on the next cycle. A second case puts the last channel's pulse on the first pixel of a new line, and there it expects no `pix_sol`.

// File: rtl/vblank_pkg.sv
package vblank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BLANK  = 2'd2
    } vb_state_e;
endpackage

// File: rtl/vblank_done_tracker.sv
// Holds per-channel and global completion pulses until the next frame start
module vblank_done_tracker #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [NUM_CH-1:0] ch_eop,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              glb_en,
    input  logic              glb_done,
    output logic              all_done
);
    logic [NUM_CH-1:0] eop_seen_q;
    logic              glb_seen_q;
    logic [NUM_CH-1:0] ch_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_seen_q <= '0;
            glb_seen_q <= 1'b0;
        end else if (clear) begin
            eop_seen_q <= '0;
            glb_seen_q <= 1'b0;
        end else begin
            eop_seen_q <= eop_seen_q | ch_eop;
            glb_seen_q <= glb_seen_q | glb_done;
        end
    end

    // a pulse counts in the cycle it arrives as well as afterwards
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_ok[i] = !ch_en[i] || eop_seen_q[i] || ch_eop[i];
    end

    assign all_done = (&ch_ok) && (!glb_en || glb_seen_q || glb_done);
endmodule

// File: rtl/vblank_pix_counter.sv
// Pixel position within a dummy line; wraps at the effective width
module vblank_pix_counter #(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [WIDTH_W-1:0] frame_width,
    output logic               at_first,
    output logic               at_last
);
    logic [WIDTH_W-1:0] pos_q;
    logic [WIDTH_W-1:0] last_pos;

    assign last_pos = (frame_width == '0) ? '0 : frame_width - 1'b1;
    assign at_first = (pos_q == '0);
    assign at_last  = (pos_q == last_pos);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q <= '0;
        end else if (run) begin
            pos_q <= at_last ? '0 : pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/vblank_line_gen.sv
module vblank_line_gen
    import vblank_pkg::*;
#(
    parameter int WIDTH_W = 12,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               last_line_done,
    input  logic [WIDTH_W-1:0] frame_width,
    input  logic [NUM_CH-1:0]  ch_eop,
    input  logic [NUM_CH-1:0]  ch_en,
    input  logic               glb_en,
    input  logic               glb_done,
    input  logic               line_mode,
    output logic [DATA_W-1:0]  pix_data,
    output logic               pix_valid,
    output logic               pix_sol,
    output logic               pix_eol,
    output logic               blank_active
);
    vb_state_e state_q, state_d;
    logic      all_done;
    logic      at_first, at_last;
    logic      start_frame;
    logic      run_pix;

    assign start_frame = (state_q == ST_IDLE) && frame_start;
    assign run_pix     = (state_q == ST_BLANK) && !all_done;

    vblank_done_tracker #(.NUM_CH(NUM_CH)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_frame),
        .ch_eop   (ch_eop),
        .ch_en    (ch_en),
        .glb_en   (glb_en),
        .glb_done (glb_done),
        .all_done (all_done)
    );

    vblank_pix_counter #(.WIDTH_W(WIDTH_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (state_q != ST_BLANK),
        .run         (run_pix),
        .frame_width (frame_width),
        .at_first    (at_first),
        .at_last     (at_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (last_line_done) begin
                    if (line_mode || all_done) state_d = ST_IDLE;
                    else                       state_d = ST_BLANK;
                end
            end
            ST_BLANK: begin
                if (all_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pix_data     = '0;
        pix_valid    = 1'b0;
        pix_sol      = 1'b0;
        pix_eol      = 1'b0;
        blank_active = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: ;
            ST_BLANK: begin
                blank_active = 1'b1;
                pix_valid    = !all_done;
                pix_sol      = !all_done && at_first;
                pix_eol      = !all_done && at_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vblank_line_gen_chk.sv
module vblank_line_gen_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              last_line_done,
    input logic              line_mode,
    input logic [DATA_W-1:0] pix_data,
    input logic              pix_valid,
    input logic              pix_sol,
    input logic              pix_eol,
    input logic              blank_active
);
    // R3
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_data == '0));

    // R2
    valid_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> blank_active);

    // R4
    sol_eol_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sol || pix_eol) |-> pix_valid);

    // R4
    next_line_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_eol) |=> (pix_sol || !pix_valid));

    // R8
    end_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_active && !pix_valid) |=> !blank_active);

    // R10
    line_mode_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_line_done && line_mode && !blank_active) |=> !blank_active);
endmodule

bind vblank_line_gen vblank_line_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .last_line_done (last_line_done),
    .line_mode      (line_mode),
    .pix_data       (pix_data),
    .pix_valid      (pix_valid),
    .pix_sol        (pix_sol),
    .pix_eol        (pix_eol),
    .blank_active   (blank_active)
);

// File: tb/test_vblank_line_gen.sv
module test_vblank_line_gen;
    localparam int WIDTH_W = 12;
    localparam int NUM_CH  = 4;
    localparam int DATA_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               frame_start, last_line_done;
    logic [WIDTH_W-1:0] frame_width;
    logic [NUM_CH-1:0]  ch_eop, ch_en;
    logic               glb_en, glb_done, line_mode;
    logic [DATA_W-1:0]  pix_data;
    logic               pix_valid, pix_sol, pix_eol, blank_active;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vblank_line_gen #(.WIDTH_W(WIDTH_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_vblank_line_gen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .last_line_done(last_line_done),
        .frame_width(frame_width), .ch_eop(ch_eop), .ch_en(ch_en), .glb_en(glb_en),
        .glb_done(glb_done), .line_mode(line_mode), .pix_data(pix_data),
        .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol), .blank_active(blank_active)
    );

    // vector: [10]frame_start [9]last_line_done [8:5]ch_eop [4]glb_done
    //         [3:0] expected {valid, sol, eol, blank}
    // run with frame_width=3, ch_en=0011, glb_en=1, frame mode
    localparam int NV = 15;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'b0000, 1'b0, 4'b0000},  // idle -> active
        {1'b0, 1'b0, 4'b0001, 1'b0, 4'b0000},  // ch0 done early (R6)
        {1'b0, 1'b1, 4'b0000, 1'b0, 4'b0000},  // last line -> blank (R2)
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b1101},  // pix0 sol (R4)
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001},  // pix1
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b1011},  // pix2 eol (R4)
        {1'b0, 1'b0, 4'b0010, 1'b0, 4'b1101},  // new line; glb still missing (R7)
        {1'b0, 1'b0, 4'b0000, 1'b1, 4'b0001},  // glb arrives -> cut (R8)
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b0000},  // idle
        {1'b1, 1'b0, 4'b0000, 1'b0, 4'b0000},  // frame 2
        {1'b0, 1'b1, 4'b0011, 1'b0, 4'b0000},  // channels done, glb not
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b1101},
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001},
        {1'b0, 1'b0, 4'b0000, 1'b1, 4'b0001},  // done on last pixel: no eol (R8)
        {1'b0, 1'b0, 4'b0000, 1'b0, 4'b0000}
    };

    task automatic check_out(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {pix_valid, pix_sol, pix_eol, blank_active};
        checks++;
        if (act !== exp || (pix_valid && pix_data !== '0)) begin
            fails++;
            $display("FAIL %s: {valid,sol,eol,blank} act=%b exp=%b data=%h exp_data=0",
                     tag, act, exp, pix_data);
        end
    endtask

    task automatic step(input logic fs, input logic ll, input logic [3:0] eop,
                        input logic gd, input logic [3:0] exp, input string tag);
        @(negedge clk);
        frame_start = fs; last_line_done = ll; ch_eop = eop; glb_done = gd;
        #1;
        check_out(exp, tag);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_start = 0; last_line_done = 0; ch_eop = '0; glb_done = 0;
        frame_width = 12'd3; ch_en = 4'b0011; glb_en = 1'b1; line_mode = 1'b0;
        repeat (3) @(negedge clk);
        #1 check_out(4'b0000, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 4'b0000, 0, 4'b0000, "R1 after reset");

        for (int i = 0; i < NV; i++)
            step(VEC[i][10], VEC[i][9], VEC[i][8:5], VEC[i][4], VEC[i][3:0],
                 $sformatf("R2/R3/R4/R6/R7/R8 vector %0d", i));

        // R10 line mode skips blanking
        line_mode = 1'b1;
        step(1, 0, 4'b0000, 0, 4'b0000, "R10 start");
        step(0, 1, 4'b0000, 0, 4'b0000, "R10 last line");
        step(0, 0, 4'b0000, 0, 4'b0000, "R10 no blank");
        step(0, 0, 4'b0000, 0, 4'b0000, "R10 idle");
        line_mode = 1'b0;

        // R9 completion already met at last line
        step(1, 0, 4'b0000, 0, 4'b0000, "R9 start");
        step(0, 0, 4'b0011, 0, 4'b0000, "R9 eop");
        step(0, 0, 4'b0000, 1, 4'b0000, "R9 glb");
        step(0, 1, 4'b0000, 0, 4'b0000, "R9 last line");
        step(0, 0, 4'b0000, 0, 4'b0000, "R9 no blank");

        // R5 zero width, R7 glb_done ignored when disabled
        frame_width = '0; ch_en = 4'b0100; glb_en = 1'b0;
        step(1, 0, 4'b0000, 0, 4'b0000, "R5 start");
        step(0, 1, 4'b0000, 0, 4'b0000, "R5 last line");
        step(0, 0, 4'b0000, 1, 4'b1111, "R7 glb ignored, R5 1-pixel line");
        step(0, 0, 4'b0000, 0, 4'b1111, "R5 second 1-pixel line");
        step(0, 0, 4'b0100, 0, 4'b0001, "R6 ch2 done");
        step(0, 0, 4'b0000, 0, 4'b0000, "R8 idle after end");

        // R6 disabled channels ignored
        frame_width = 12'd2; ch_en = 4'b0001;
        step(1, 0, 4'b0000, 0, 4'b0000, "R6 start");
        step(0, 1, 4'b0000, 0, 4'b0000, "R6 last line");
        step(0, 0, 4'b1110, 0, 4'b1101, "R6 disabled eop ignored");
        step(0, 0, 4'b0000, 0, 4'b1011, "R4 width 2 eol");
        step(0, 0, 4'b0001, 0, 4'b0001, "R8 cut at line start, no sol");
        step(0, 0, 4'b0000, 0, 4'b0000, "R8 idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule